// File: doc/BRIEF.md
# Interrupt status and mask unit

This unit sits between a bus interface controller and its host processor. It latches twelve interface events into two 8-bit status registers, gates them with two enable registers that the host writes, and drives a single active-high interrupt line. Eight events arrive as one-cycle pulses. Four more are derived inside the unit from changes of state levels: serial poll active, local lockout, remote, and addressed. Three of those levels and the interrupt line itself are shown live in the second status register. They are never latched and can never be masked.

The host reads a status register to learn which events fired, and that read clears the latched bits. An event that lands while its register is being read is kept aside and set into the register once the clear completes, so no event is lost. The second enable register also holds two DMA enable bits, which are brought out as plain outputs. A synchronous power-on clear returns all status, held events and enables to zero.

Top module: `irq_status_unit`

## Requirements
- R1: Status register 1 (select 0) latches event pulse `ev_pulse[i]` into bit i. The bit names are 7 UCMD, 6 SADR, 5 TRIG, 4 EOM, 3 DCLR, 2 NOLSN, 1 TXRDY and 0 RXRDY. When no read of that register is in progress, the bit is set at the clock edge that samples the pulse, whatever its enable bit holds.
- R2: `rd_data` combinationally shows the selected register. Select 1 gives bit 7 as the live `irq`, bits 6/5/4 as the live `lvl_sp`/`lvl_lockout`/`lvl_remote`, and bits 3..0 as the latched change flags POLLCHG, LOCKCHG, RMTCHG and ADRCHG.
- R3: A change of `lvl_sp`, `lvl_lockout`, `lvl_remote` or `lvl_addressed` in either direction sets status-2 bit 3, 2, 1 or 0 respectively, at the edge that first samples the new level.
- R4: ADRCHG is not set while `talk_only` or `listen_only` is high, including for an addressed-level change made during that time.
- R5: A read (`reg_rd` high for one or more cycles) clears the latched bits of the selected register only, at the first clock edge after the strobe drops. The other status register and both enable registers are unaffected.
- R6: While the read strobe of a register is high, that register's latched bits hold steady. Events for that register that arrive during the read are held and set into the register at the clearing edge.
- R7: A write with select 0 loads enable register 1 with `wr_data`. A write with select 1 loads bits 5..0 of enable register 2 and forces bits 7..6 to zero. Bit 5 drives `dma_out_en` and bit 4 drives `dma_in_en`. Bits 3..0 enable POLLCHG, LOCKCHG, RMTCHG and ADRCHG.
- R8: `irq` is registered and equals the OR over all twelve sources of status AND enable. It changes at the same edge as the status or enable bit that causes the change.
- R9: The live level bits never assert `irq`, whatever the enables hold.
- R10: `por_clr` clears both status registers, any held events and both enable registers at the next edge. A level change that coincides with `por_clr`, or is present when reset is released, is not reported as a change.
- R11: After reset, `irq`, `dma_out_en` and `dma_in_en` are low and all latched status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| por_clr | input | 1 | Synchronous power-on clear |
| reg_addr | input | 1 | Register select: 0 = status/enable 1, 1 = status/enable 2 |
| reg_wr | input | 1 | Write strobe for the selected enable register |
| reg_rd | input | 1 | Read strobe for the selected status register (read-to-clear) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Selected status register contents |
| ev_pulse | input | 8 | One-cycle event pulses, bit i sets status-1 bit i |
| lvl_sp | input | 1 | Serial poll active level |
| lvl_lockout | input | 1 | Local lockout level |
| lvl_remote | input | 1 | Remote (high) / local (low) level |
| lvl_addressed | input | 1 | Addressed (high) / unaddressed (low) level |
| talk_only | input | 1 | Talk-only mode flag, suppresses ADRCHG |
| listen_only | input | 1 | Listen-only mode flag, suppresses ADRCHG |
| irq | output | 1 | Active-high interrupt request |
| dma_out_en | output | 1 | DMA-out enable bit from enable register 2 |
| dma_in_en | output | 1 | DMA-in enable bit from enable register 2 |

## Verification
The assertions take the read strobe to address one register for the whole of a read. They also take a register not to be read twice with no idle cycle between the reads. The clear-after-read property further requires that no events arrive in the read cycle or the cycle that follows, so the held set is known to be empty. The stimulus holds `reg_addr` fixed while `reg_rd` is high and always leaves an idle cycle after each read. Events are driven during a read only in the one test that checks holding, and the clear-after-read property is not triggered in that test.

// File: rtl/irqsu_pkg.sv
package irqsu_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CHG_W    = 4;
  localparam int unsigned ADDR_W   = 1;
  localparam int unsigned SRC_W    = DATA_W + CHG_W;

  localparam logic [ADDR_W-1:0] SEL_S1 = 1'b0;
  localparam logic [ADDR_W-1:0] SEL_S2 = 1'b1;

  // Enable register 2 layout
  localparam int unsigned EN2_DMA_OUT = 5;
  localparam int unsigned EN2_DMA_IN  = 4;
  localparam logic [DATA_W-1:0] EN2_MASK = DATA_W'((1 << (EN2_DMA_OUT + 1)) - 1);

  // Change detector lanes (also status-2 bit positions)
  localparam int unsigned LN_POLL = 3;
  localparam int unsigned LN_LOCK = 2;
  localparam int unsigned LN_RMT  = 1;
  localparam int unsigned LN_ADR  = 0;
endpackage

// File: rtl/irqsu_sticky.sv
module irqsu_sticky #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         rd_hit,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] stat_d,
  output logic         rd_q
);
  logic [W-1:0] hold_q, hold_d;
  logic         rd_d;
  logic         upd_en;

  always_comb begin
    stat_d = stat_q;
    hold_d = hold_q;
    rd_d   = rd_hit;
    if (clr) begin
      stat_d = '0;
      hold_d = '0;
      rd_d   = 1'b0;
    end else if (rd_hit) begin
      hold_d = hold_q | set_vec;          // park events while the host reads
    end else if (rd_q) begin
      stat_d = hold_q | set_vec;          // clear, then drop parked events in
      hold_d = '0;
    end else begin
      stat_d = stat_q | set_vec;
    end
  end

  assign upd_en = clr | rd_hit | rd_q | (|set_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      hold_q <= '0;
      rd_q   <= 1'b0;
    end else if (upd_en) begin
      stat_q <= stat_d;
      hold_q <= hold_d;
      rd_q   <= rd_d;
    end
  end
endmodule

// File: rtl/irqsu_edge_det.sv
module irqsu_edge_det #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] lvl_in,
  input  logic [N-1:0] gate,
  output logic [N-1:0] chg
);
  logic [N-1:0] lvl_q;
  logic         prime_q;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign chg[i] = prime_q & ~clr & gate[i] & (lvl_in[i] ^ lvl_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      prime_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_in;
      prime_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irqsu_irq_gen.sv
module irqsu_irq_gen #(
  parameter int unsigned N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_d,
  input  logic [N-1:0] en_d,
  output logic         irq_q
);
  logic irq_d;

  assign irq_d = |(src_d & en_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irqsu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_clr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [DATA_W-1:0]   ev_pulse,
  input  logic                lvl_sp,
  input  logic                lvl_lockout,
  input  logic                lvl_remote,
  input  logic                lvl_addressed,
  input  logic                talk_only,
  input  logic                listen_only,
  output logic                irq,
  output logic                dma_out_en,
  output logic                dma_in_en
);
  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // Decode
  logic rd_s1, rd_s2, wr_s1, wr_s2;
  assign rd_s1 = reg_rd & (reg_addr == SEL_S1);
  assign rd_s2 = reg_rd & (reg_addr == SEL_S2);
  assign wr_s1 = reg_wr & (reg_addr == SEL_S1);
  assign wr_s2 = reg_wr & (reg_addr == SEL_S2);

  // Enable registers
  logic [DATA_W-1:0] en1_q, en1_d, en2_q, en2_d;
  logic              en_upd;

  always_comb begin
    en1_d = en1_q;
    en2_d = en2_q;
    if (por_clr) begin
      en1_d = '0;
      en2_d = '0;
    end else begin
      if (wr_s1) en1_d = wr_data;
      if (wr_s2) en2_d = wr_data & EN2_MASK;
    end
  end

  assign en_upd = por_clr | reg_wr;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en1_q <= '0;
      en2_q <= '0;
    end else if (en_upd) begin
      en1_q <= en1_d;
      en2_q <= en2_d;
    end
  end

  // Level change detection
  logic [CHG_W-1:0] lvl_vec, lvl_gate, chg_vec;

  always_comb begin
    lvl_vec          = '0;
    lvl_vec[LN_POLL] = lvl_sp;
    lvl_vec[LN_LOCK] = lvl_lockout;
    lvl_vec[LN_RMT]  = lvl_remote;
    lvl_vec[LN_ADR]  = lvl_addressed;
    lvl_gate         = '1;
    lvl_gate[LN_ADR] = ~(talk_only | listen_only);
  end

  irqsu_edge_det #(.N(CHG_W)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (por_clr),
    .lvl_in (lvl_vec),
    .gate   (lvl_gate),
    .chg    (chg_vec)
  );

  // Latched status
  logic [DATA_W-1:0] st1_q, st1_d;
  logic [CHG_W-1:0]  st2_q, st2_d;
  logic              rd1_q, rd2_q;

  irqsu_sticky #(.W(DATA_W)) u_st1 (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (por_clr),
    .rd_hit  (rd_s1),
    .set_vec (ev_pulse),
    .stat_q  (st1_q),
    .stat_d  (st1_d),
    .rd_q    (rd1_q)
  );

  irqsu_sticky #(.W(CHG_W)) u_st2 (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (por_clr),
    .rd_hit  (rd_s2),
    .set_vec (chg_vec),
    .stat_q  (st2_q),
    .stat_d  (st2_d),
    .rd_q    (rd2_q)
  );

  // Interrupt line
  irqsu_irq_gen #(.N(SRC_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .src_d  ({st2_d, st1_d}),
    .en_d   ({en2_d[CHG_W-1:0], en1_d}),
    .irq_q  (irq)
  );

  // Read view
  always_comb begin
    if (reg_addr == SEL_S1) rd_data = st1_q;
    else                    rd_data = {irq, lvl_sp, lvl_lockout, lvl_remote, st2_q};
  end

  assign dma_out_en = en2_q[EN2_DMA_OUT];
  assign dma_in_en  = en2_q[EN2_DMA_IN];
endmodule

// File: rtl/irqsu_checker.sv
module irqsu_checker
  import irqsu_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                por_clr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [DATA_W-1:0]   wr_data,
  input logic [DATA_W-1:0]   ev_pulse,
  input logic                talk_only,
  input logic                listen_only,
  input logic                irq,
  input logic                dma_out_en,
  input logic                dma_in_en,
  input logic [DATA_W-1:0]   st1_q,
  input logic [CHG_W-1:0]    st2_q,
  input logic [DATA_W-1:0]   en1_q,
  input logic [DATA_W-1:0]   en2_q,
  input logic                rd1_q,
  input logic                rd2_q
);
  logic c_rd1, c_rd2, c_wr1, c_wr2;
  assign c_rd1 = reg_rd && (reg_addr == SEL_S1);
  assign c_rd2 = reg_rd && (reg_addr == SEL_S2);
  assign c_wr1 = reg_wr && (reg_addr == SEL_S1);
  assign c_wr2 = reg_wr && (reg_addr == SEL_S2);

  a_r1_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_rd1 && !rd1_q && !por_clr) |=> ((st1_q & $past(ev_pulse)) == $past(ev_pulse)));

  a_r4_no_adrchg_fixed_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ((talk_only || listen_only) && !st2_q[LN_ADR] && !c_rd2 && !rd2_q) |=> !st2_q[LN_ADR]);

  a_r5_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_rd1 && $past(c_rd1) && !$past(c_rd1, 2) && ev_pulse == '0 &&
     $past(ev_pulse) == '0 && !por_clr) |=> (st1_q == '0));

  a_r6_stable_read1: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd1 && !por_clr) |=> $stable(st1_q));

  a_r6_stable_read2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd2 && !por_clr) |=> $stable(st2_q));

  a_r7_write_en1: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr1 && !por_clr) |=> (en1_q == $past(wr_data)));

  a_r7_write_en2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr2 && !por_clr) |=> (en2_q == $past(wr_data & EN2_MASK) &&
                             dma_out_en == $past(wr_data[EN2_DMA_OUT]) &&
                             dma_in_en == $past(wr_data[EN2_DMA_IN])));

  a_r8_irq_is_masked_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((|(st1_q & en1_q)) || (|(st2_q & en2_q[CHG_W-1:0]))));

  a_r10_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
    por_clr |=> (st1_q == '0 && st2_q == '0 && en1_q == '0 && en2_q == '0 && !irq));
endmodule

bind irq_status_unit irqsu_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .por_clr     (por_clr),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .wr_data     (wr_data),
  .ev_pulse    (ev_pulse),
  .talk_only   (talk_only),
  .listen_only (listen_only),
  .irq         (irq),
  .dma_out_en  (dma_out_en),
  .dma_in_en   (dma_in_en),
  .st1_q       (st1_q),
  .st2_q       (st2_q),
  .en1_q       (en1_q),
  .en2_q       (en2_q),
  .rd1_q       (rd1_q),
  .rd2_q       (rd2_q)
);

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       por_clr;
  logic [0:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] wr_data, rd_data, ev_pulse;
  logic       lvl_sp, lvl_lockout, lvl_remote, lvl_addressed;
  logic       talk_only, listen_only;
  logic       irq, dma_out_en, dma_in_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_status_unit dut (
    .clk(clk), .rst_n(rst_n), .por_clr(por_clr), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .wr_data(wr_data), .rd_data(rd_data),
    .ev_pulse(ev_pulse), .lvl_sp(lvl_sp), .lvl_lockout(lvl_lockout),
    .lvl_remote(lvl_remote), .lvl_addressed(lvl_addressed),
    .talk_only(talk_only), .listen_only(listen_only),
    .irq(irq), .dma_out_en(dma_out_en), .dma_in_en(dma_in_en)
  );

  // {events[16:9], enable1[8:1], expected irq[0]}
  localparam logic [16:0] VEC [6] = '{
    {8'h01, 8'h01, 1'b1},
    {8'h80, 8'h7F, 1'b0},
    {8'h24, 8'h20, 1'b1},
    {8'hFF, 8'h00, 1'b0},
    {8'h5A, 8'hA5, 1'b0},
    {8'h18, 8'h10, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [7:0] s2_exp(input logic irq_e, input logic [3:0] chg);
    return {irq_e, lvl_sp, lvl_lockout, lvl_remote, chg};
  endfunction

  task automatic wr(input logic [0:0] a, input logic [7:0] d);
    reg_addr = a; wr_data = d; reg_wr = 1'b1;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [0:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = rd_data;
    cyc();
    reg_rd = 1'b0;
    cyc();
  endtask

  task automatic por();
    por_clr = 1'b1;
    cyc();
    por_clr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] ev);
    ev_pulse = ev;
    cyc();
    ev_pulse = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; por_clr = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    wr_data = '0; ev_pulse = '0; lvl_sp = 1'b0; lvl_lockout = 1'b0;
    lvl_remote = 1'b1; lvl_addressed = 1'b0; talk_only = 1'b0; listen_only = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();

    // R11 reset state, R10 no false change for level high at reset
    chk("R11 irq after reset", {7'd0, irq}, 8'h00);
    chk("R11 dma after reset", {6'd0, dma_out_en, dma_in_en}, 8'h00);
    rd(1'b0, d); chk("R11 status1 after reset", d, 8'h00);
    rd(1'b1, d); chk("R10 status2 no false change at reset", d, s2_exp(1'b0, 4'h0));

    // Table: R1 latching, R8 masking, R2 irq mirror, R5 clear
    for (int k = 0; k < 6; k++) begin
      por();
      wr(1'b0, VEC[k][8:1]);
      pulse(VEC[k][16:9]);
      chk("R8 irq after event", {7'd0, irq}, {7'd0, VEC[k][0]});
      rd(1'b1, d); chk("R2 status2 irq mirror", d, s2_exp(VEC[k][0], 4'h0));
      rd(1'b0, d); chk("R1 status1 latched events", d, VEC[k][16:9]);
      chk("R8 irq low after clear", {7'd0, irq}, 8'h00);
      rd(1'b0, d); chk("R5 status1 cleared by read", d, 8'h00);
    end

    // R3 change detection, both directions, all four lanes
    por();
    wr(1'b1, 8'h0F);
    lvl_sp = 1'b1; cyc();
    chk("R3 irq on poll change", {7'd0, irq}, 8'h01);
    rd(1'b1, d); chk("R3 poll rise", d, s2_exp(1'b1, 4'b1000));
    rd(1'b1, d); chk("R2 live poll bit after clear", d, s2_exp(1'b0, 4'b0000));
    lvl_sp = 1'b0; cyc();
    rd(1'b1, d); chk("R3 poll fall", d, s2_exp(1'b1, 4'b1000));
    lvl_lockout = 1'b1; cyc();
    rd(1'b1, d); chk("R3 lockout rise", d, s2_exp(1'b1, 4'b0100));
    lvl_remote = 1'b0; cyc();
    rd(1'b1, d); chk("R3 remote fall", d, s2_exp(1'b1, 4'b0010));
    lvl_addressed = 1'b1; cyc();
    rd(1'b1, d); chk("R3 addressed rise", d, s2_exp(1'b1, 4'b0001));

    // R4 fixed modes suppress address change
    talk_only = 1'b1; lvl_addressed = 1'b0; cyc();
    rd(1'b1, d); chk("R4 talk-only no adrchg", d, s2_exp(1'b0, 4'b0000));
    talk_only = 1'b0; listen_only = 1'b1; lvl_addressed = 1'b1; cyc();
    rd(1'b1, d); chk("R4 listen-only no adrchg", d, s2_exp(1'b0, 4'b0000));
    listen_only = 1'b0; lvl_addressed = 1'b0; cyc();
    rd(1'b1, d); chk("R4 adrchg back after mode off", d, s2_exp(1'b1, 4'b0001));

    // R7 enable register 2 and DMA bits
    wr(1'b1, 8'hFF);
    chk("R7 dma both set", {6'd0, dma_out_en, dma_in_en}, 8'h03);
    wr(1'b1, 8'hD0);
    chk("R7 dma in only", {6'd0, dma_out_en, dma_in_en}, 8'h01);

    // R9 live bits never interrupt
    por();
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h30);
    lvl_sp = 1'b1; lvl_remote = 1'b1; cyc();
    chk("R9 irq stays low with live bits high", {7'd0, irq}, 8'h00);
    rd(1'b1, d); chk("R9 status2 live bits", d, s2_exp(1'b0, 4'b1010));

    // R6 event during a two-cycle read is held
    por();
    wr(1'b0, 8'h04);
    reg_addr = 1'b0; reg_rd = 1'b1; ev_pulse = 8'h04;
    #1 chk("R6 read value before event", rd_data, 8'h00);
    cyc();
    ev_pulse = '0;
    #1 chk("R6 status stable while read held", rd_data, 8'h00);
    chk("R6 irq held off during read", {7'd0, irq}, 8'h00);
    cyc();
    reg_rd = 1'b0;
    cyc();
    chk("R6 irq after held event placed", {7'd0, irq}, 8'h01);
    rd(1'b0, d); chk("R6 held event placed after clear", d, 8'h04);

    // R5 read of one register leaves the other alone
    por();
    ev_pulse = 8'h01; lvl_sp = 1'b0; cyc();
    ev_pulse = '0;
    rd(1'b1, d); chk("R5 status2 read", d, s2_exp(1'b0, 4'b1000));
    rd(1'b0, d); chk("R5 status1 untouched by status2 read", d, 8'h01);

    // R10 power-on clear
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h30);
    pulse(8'h02);
    chk("R10 irq before clear", {7'd0, irq}, 8'h01);
    por_clr = 1'b1; lvl_remote = 1'b0; cyc();
    por_clr = 1'b0;
    chk("R10 irq cleared", {7'd0, irq}, 8'h00);
    chk("R10 dma cleared", {6'd0, dma_out_en, dma_in_en}, 8'h00);
    rd(1'b0, d); chk("R10 status1 cleared", d, 8'h00);
    rd(1'b1, d); chk("R10 no change reported at clear", d, s2_exp(1'b0, 4'b0000));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule